// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block drives a two-wire management interface (MDC clock, bidirectional MDIO data) toward one or more PHYs. Software sees two 32-bit registers: a control register that sets the MDC rate and preamble option, and a command/data register. When software writes a command word with the start bit set into the command/data register, the block sends that word bit by bit on MDIO, most significant bit first. The command word already carries the whole management frame at fixed bit positions: the start pattern, the operation, the PHY and register addresses, the turnaround and sixteen data bits. An optional 32-bit preamble of ones can be sent before it.

On a read frame the block stops driving MDIO from the turnaround onward. It samples sixteen bits from the PHY and puts them in the low half of the command/data register. When the last bit has gone out, a sticky completion flag in the control register is set. Software polls this flag and then reads the result. Writing zero to the control register stops the interface. Selecting a PHY through a separate write to register 0x1F is an ordinary write frame for this block: the PHY number sits in the data bits and the device field is left zero.

Top module: `mdio_master_regs`

## Requirements
- R1: Out of reset, both registers read as zero, MDC is low and MDIO is not driven (mdio_oe low).
- R2: The control register sits at offset 0x128. Bits 6:0 hold the divisor, bit 7 enables the preamble and bit 8 is the read-only completion flag. All other bits read as zero. A control write while a frame is in flight has no effect.
- R3: A write to offset 0x12C while idle is stored. If bit 30 of the word is set and the divisor is nonzero, it starts a frame. The frame sends word bits 31 down to 0, one per MDC period, and all 32 bits are driven when bit 29 is clear.
- R4: MDC stays low for exactly divisor clock cycles and then high for divisor cycles. MDIO changes only together with a falling MDC edge, so it is stable at every rising edge.
- R5: With control bit 7 set, the frame is preceded by 32 driven ones. With bit 7 clear, the frame begins directly with word bit 31.
- R6: When word bit 29 is set (read), mdio_oe is low for word bits 17 down to 0. The 16 bits present on mdio_in at the rising MDC edges of bits 15 down to 0 land in register bits 15:0, first-received bit highest. Bits 31:16 keep their written value.
- R7: The completion flag (control bit 8) is set on the clock edge that ends the frame. It stays set until the next frame starts, and it is cleared on that start edge.
- R8: A write to offset 0x12C while a frame is in flight is ignored. It changes neither the frame on the wire nor the register contents.
- R9: While the divisor is zero, or when bit 30 of the written word is clear, a write to 0x12C stores the word but starts no frame. MDC stays low and the completion flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value from the pad |

## Verification
The hardest cases to reach are the register writes that land while a frame is in flight. A control or command write has to arrive between MDC edges of an active frame, and the bench must then prove from the wire and from readback that nothing changed. The stimulus starts a read frame at the fastest divisor, reads the control register at once to see the completion flag already cleared, and then issues a competing control write and a competing command write well before the 32nd bit. A PHY responder in the bench drives mdio_in after each rising edge that falls inside the released window. The captured value, the untouched upper half and the unchanged divisor are then checked against the values the first write set up.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
  // register offsets
  localparam logic [11:0] CTRL_OFS = 12'h128;
  localparam logic [11:0] DATA_OFS = 12'h12C;
  // frame layout inside the command word (shifted out msb first)
  localparam int WORD_W   = 32;
  localparam int START_B  = 30;
  localparam int READ_B   = 29;
  localparam int TA_HI    = 17;   // first bit released on a read
  localparam int RDATA_W  = 16;
  localparam int PRE_LEN  = 32;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] hc_q, hc_d;
  logic             mdc_q, mdc_d;
  logic             tick;

  assign tick = run && (hc_q == (div - ONE));

  always_comb begin
    hc_d  = hc_q;
    mdc_d = mdc_q;
    if (!run) begin
      hc_d  = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      hc_d  = '0;
      mdc_d = ~mdc_q;
    end else begin
      hc_d  = hc_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q  <= '0;
      mdc_q <= 1'b0;
    end else begin
      hc_q  <= hc_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc  = mdc_q;
  assign rise = tick && !mdc_q;
  assign fall = tick && mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_master_pkg::*;
#(
  parameter int PRE_BITS = PRE_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pre_en,
  input  logic [WORD_W-1:0] word,
  input  logic              rise,
  input  logic              fall,
  output logic              busy,
  output logic              finish,
  output logic              cap_en,
  output logic              mdio_out,
  output logic              mdio_oe
);
  localparam int CNT_W = $clog2(WORD_W + PRE_BITS);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LOAD_PRE = CNT_W'(WORD_W + PRE_BITS - 1);
  localparam logic [CNT_W-1:0] LOAD_RAW = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] WORD_LIM = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] REL_HI   = CNT_W'(TA_HI);
  localparam logic [CNT_W-1:0] CAP_LIM  = CNT_W'(RDATA_W);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             in_pre, is_rd, released, last_bit;

  assign in_pre   = cnt_q >= WORD_LIM;
  assign is_rd    = word[READ_B];
  assign released = is_rd && !in_pre && (cnt_q <= REL_HI);
  assign last_bit = cnt_q == '0;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = pre_en ? LOAD_PRE : LOAD_RAW;
    end else if (busy_q && fall) begin
      if (last_bit) busy_d = 1'b0;
      else          cnt_d  = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy     = busy_q;
  assign finish   = busy_q && fall && last_bit;
  assign cap_en   = busy_q && rise && is_rd && !in_pre && (cnt_q < CAP_LIM);
  assign mdio_out = in_pre ? 1'b1 : word[cnt_q[IDX_W-1:0]];
  assign mdio_oe  = busy_q && !released;
endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
  import mdio_master_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              busy,
  input  logic              finish,
  input  logic              cap_en,
  input  logic              cap_bit,
  output logic [WORD_W-1:0] rdata,
  output logic              start,
  output logic [DIV_W-1:0]  div,
  output logic              pre_en,
  output logic [WORD_W-1:0] word,
  output logic              done
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
  localparam int PAD_W = WORD_W - DIV_W - 2;

  logic [DIV_W-1:0]  div_q, div_d;
  logic              pre_q, pre_d;
  logic              done_q, done_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              wr_ctrl, wr_data;

  assign wr_ctrl = wr_en && (addr == CTRL_A) && !busy;
  assign wr_data = wr_en && (addr == DATA_A) && !busy;
  assign start   = wr_data && wdata[START_B] && (div_q != '0);

  always_comb begin
    div_d  = div_q;
    pre_d  = pre_q;
    done_d = done_q;
    data_d = data_q;
    if (wr_ctrl) begin
      div_d = wdata[DIV_W-1:0];
      pre_d = wdata[DIV_W];
    end
    if (wr_data) data_d = wdata;
    else if (cap_en) data_d = {data_q[WORD_W-1:RDATA_W], data_q[RDATA_W-2:0], cap_bit};
    if (start)       done_d = 1'b0;
    else if (finish) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      pre_q  <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      div_q  <= div_d;
      pre_q  <= pre_d;
      done_q <= done_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    if (addr == CTRL_A)      rdata = {{PAD_W{1'b0}}, done_q, pre_q, div_q};
    else if (addr == DATA_A) rdata = data_q;
    else                     rdata = '0;
  end

  assign div    = div_q;
  assign pre_en = pre_q;
  assign word   = data_q;
  assign done   = done_q;
endmodule

// File: rtl/mdio_master_regs.sv
module mdio_master_regs
  import mdio_master_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              busy, finish, cap_en, start, pre_en, done;
  logic              rise, fall;
  logic [DIV_W-1:0]  div;
  logic [WORD_W-1:0] word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mdio_reg_file #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .finish(finish), .cap_en(cap_en),
    .cap_bit(mdio_in), .rdata(reg_rdata), .start(start), .div(div),
    .pre_en(pre_en), .word(word), .done(done)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) mdc_i (
    .clk(clk), .rst_n(rst_int_n), .run(busy), .div(div),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_seq #(.PRE_BITS(PRE_LEN)) seq_i (
    .clk(clk), .rst_n(rst_int_n), .start(start), .pre_en(pre_en),
    .word(word), .rise(rise), .fall(fall), .busy(busy), .finish(finish),
    .cap_en(cap_en), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DIV_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             mdc,
  input logic             mdio_out,
  input logic             mdio_oe,
  input logic [DIV_W-1:0] div,
  input logic [15:0]      data_hi
);
  // R4
  mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && !$stable(mdio_out)) |-> $fell(mdc));
  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));
  // R7
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data_hi));
  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div));
endmodule

bind mdio_master_regs mdio_master_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mdc(mdc),
  .mdio_out(mdio_out), .mdio_oe(mdio_oe), .div(div), .data_hi(word[31:16])
);

// File: tb/mdio_master_regs_tb.sv
module mdio_master_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h128;
  localparam logic [11:0] A_DATA = 12'h12C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0;
  int errors = 0;
  logic [2:0]  exp_q[$];   // {first, oe, value}
  int          cur_div = 1;
  logic [15:0] resp_v = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic push_frame(input logic [31:0] w, input bit pre);
    for (int i = 0; i < 32; i++)
      if (pre) exp_q.push_back({(i == 0), 1'b1, 1'b1});
    for (int b = 31; b >= 0; b--)
      exp_q.push_back({(!pre && b == 31), !(w[29] && b <= 17), w[b]});
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    int n = 0;
    v = '0;
    while (n < 20000 && !v[8]) begin
      bus_rd(A_CTRL, v);
      n++;
    end
    chk(v[8], req, "completion flag", v, v | 32'h100);
  endtask

  task automatic run_frame(input string req, input logic [31:0] w, input bit pre,
                           input int d, input logic [15:0] resp);
    logic [31:0] v, e;
    cur_div = d;
    resp_v  = resp;
    push_frame(w, pre);
    bus_wr(A_DATA, w);
    wait_done("R7");
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, req, "bits left unsent", exp_q.size(), 0);
    bus_rd(A_DATA, v);
    e = w[29] ? {w[31:16], resp} : w;
    chk(v == e, w[29] ? "R6" : "R3", "data register after frame", v, e);
  endtask

  // monitor: pops expected bits at each rising MDC edge, answers reads
  logic mdc_prev = 1'b0;
  int   lowrun = 0;
  int   rel = 0;
  always @(negedge clk) begin
    logic [2:0] it;
    if (rst_n) begin
      if (mdc && !mdc_prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected MDC edge", 1, 0);
        end else begin
          it = exp_q.pop_front();
          chk(mdio_oe == it[1], it[1] ? "R3" : "R6", "mdio_oe at rising MDC", mdio_oe, it[1]);
          if (it[1]) chk(mdio_out == it[0], "R5", "mdio bit value", mdio_out, it[0]);
          if (!it[2]) chk(lowrun == cur_div, "R4", "MDC low time", lowrun, cur_div);
        end
        if (mdio_oe) begin
          rel = 0;
          mdio_in = 1'b1;
        end else begin
          rel++;
          mdio_in = (rel >= 2 && rel <= 17) ? resp_v[17 - rel] : 1'b1;
        end
      end
      lowrun = mdc ? 0 : lowrun + 1;
      mdc_prev = mdc;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_rd(A_CTRL, v); chk(v == 0, "R1", "control at reset", v, 0);
    bus_rd(A_DATA, v); chk(v == 0, "R1", "data at reset", v, 0);
    chk(!mdc && !mdio_oe, "R1", "pins at reset", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 field layout
    bus_wr(A_CTRL, 32'hFFFF_FFFF);
    bus_rd(A_CTRL, v); chk(v == 32'h0000_00FF, "R2", "control readback mask", v, 32'hFF);

    // R3/R5 legacy write frame with preamble, divisor 2
    bus_wr(A_CTRL, 32'h82);
    w = 32'h5000_0000 | (32'h03 << 22) | (32'h01 << 18) | (32'h1 << 17) | 32'hBEEF;
    run_frame("R3", w, 1'b1, 2, 16'h0);

    // R6 read frame with preamble
    w = 32'h6000_0000 | (32'h1D << 22) | (32'h01 << 18) | (32'h1 << 17);
    run_frame("R6", w, 1'b1, 2, 16'hA53C);

    // R5 no preamble: PHY-select write to register 0x1F
    bus_wr(A_CTRL, 32'h02);
    w = 32'h5000_0000 | (32'h1F << 18) | (32'h1 << 17) | (32'h1D << 4);
    run_frame("R5", w, 1'b0, 2, 16'h0);

    // R8/R2/R7 competing writes during a read at divisor 1
    bus_wr(A_CTRL, 32'h01);
    cur_div = 1;
    resp_v  = 16'h1234;
    w = 32'h6000_0000 | (32'h05 << 22) | (32'h02 << 18) | (32'h1 << 17);
    push_frame(w, 1'b0);
    bus_wr(A_DATA, w);
    bus_rd(A_CTRL, v); chk(v[8] == 1'b0, "R7", "flag cleared at start", v, 32'h01);
    bus_wr(A_CTRL, 32'h05);
    bus_wr(A_DATA, 32'h5000_FFFF);
    wait_done("R7");
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "bits left unsent", exp_q.size(), 0);
    bus_rd(A_DATA, v); chk(v == {w[31:16], 16'h1234}, "R8", "data after busy write", v, {w[31:16], 16'h1234});
    bus_rd(A_CTRL, v); chk(v == 32'h101, "R2", "control after busy write", v, 32'h101);

    // R9 divisor zero disables
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_DATA, 32'h5000_1234);
    repeat (40) @(negedge clk);
    chk(!mdc, "R9", "MDC idle when disabled", mdc, 0);
    bus_rd(A_DATA, v); chk(v == 32'h5000_1234, "R9", "stored word when disabled", v, 32'h5000_1234);
    bus_rd(A_CTRL, v); chk(v == 32'h100, "R9", "flag kept when disabled", v, 32'h100);

    // R9 start bit clear
    bus_wr(A_CTRL, 32'h03);
    bus_wr(A_DATA, 32'h1000_00AA);
    repeat (40) @(negedge clk);
    bus_rd(A_DATA, v); chk(v == 32'h1000_00AA, "R9", "stored word without start", v, 32'h1000_00AA);
    bus_rd(A_CTRL, v); chk(v == 32'h103, "R9", "flag kept without start", v, 32'h103);

    // R4/R6 slower read with preamble
    bus_wr(A_CTRL, 32'h85);
    w = 32'h6000_0000 | (32'h02 << 22) | (32'h1F << 18) | (32'h1 << 17);
    run_frame("R4", w, 1'b1, 5, 16'h8001);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule